// File: doc/BRIEF.md
# Fly-by Block DMA Controller

This block is a four-channel direct memory access engine that moves words between peripheral ports and memory. The data never passes through it. For every word it drives the memory address together with one memory strobe and the opposite I/O strobe. Memory and the device then exchange the word directly over the shared data bus. The processor sets up each channel through a small register port: a direction, a start address, a word count and an enable.

A device starts a transfer by raising its request line. The controller then asks the processor for the bus. It keeps off the bus until the processor returns hold acknowledge. It then acknowledges the device and runs one bus cycle per word until the count is used up. Finally it gives the bus back and flags a completion interrupt. Only one channel runs at a time. A finished transfer can be seen through a terminal-count status bit and a clear-on-read interrupt flag.

Top module: `flyby_dma`

## Requirements
- R1: Each channel has its own registers, chosen by `cfg_chan` and `cfg_reg`. Register 0 holds the current address. Register 1 holds the remaining word count, and writing it clears terminal count. Register 2 is control: bit 0 is the direction (1 = memory to device, 0 = device to memory) and bit 1 is enable. Register 3 is status: bit 0 is terminal count and bit 1 is the interrupt flag. Each register reads back on `cfg_rdata` in the same cycle.
- R2: A channel is eligible when it is enabled, its count is nonzero and its `dreq` bit is high. If a channel is eligible while the controller is idle, `hrq` goes high on the next cycle. An enabled channel whose count is zero never raises `hrq`.
- R3: No acknowledge and no strobe is driven in any cycle unless both `hrq` and `hlda` are high. If `hlda` drops during a block, the transfer pauses with no progress and resumes when `hlda` returns.
- R4: In every word cycle, exactly the active channel's `dack` bit is high and `bus_addr` carries that channel's current address.
- R5: A memory-to-device word asserts `mem_rd` together with `io_wr`. A device-to-memory word asserts `io_rd` together with `mem_wr`. Read and write of the same space are never asserted together.
- R6: After each word the address increments by one, wrapping modulo 2^AW, and the count decrements by one. After a block of N words the address reads start+N and the count reads zero.
- R7: `hrq` stays high for the whole block. It falls in the cycle after the last word, and at that point the channel's enable bit reads zero.
- R8: Finishing a block sets the channel's terminal count bit and its interrupt flag. `irq` is the OR of all interrupt flags. Reading status (`cfg_rd` with register 3) clears that channel's flag and leaves terminal count set.
- R9: Among eligible channels, channel 0 has the highest priority and channel 3 the lowest. A running block is never preempted.
- R10: A register write to the channel that is currently holding or running is ignored. A write to any other channel takes effect.
- R11: After reset, `hrq`, `dack`, all strobes and `irq` are low, and all channel registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chan | input | $clog2(NCH) | Channel addressed by the register port |
| cfg_reg | input | 2 | Register index within the channel |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (clears the interrupt flag on status reads) |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data |
| dreq | input | NCH | Device request lines |
| dack | output | NCH | Device acknowledge lines |
| hrq | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| bus_addr | output | AW | Memory address for the current word |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with four channels and an 8-bit address and count width. This keeps every word of a block cheap to watch. The bench sweeps every channel, both directions and every count from 1 to 15, with varied hold-acknowledge latency and mid-block pauses, plus a start address that wraps past 255. The narrow width brings address wrap within reach. The four channels allow a full fixed-priority ordering with a late higher-priority request. Writes landing on the running channel are tested against writes to an idle one.

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  localparam int CSW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CSW-1:0] cfg_chan,
  input  logic [1:0]     cfg_reg,
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [AW-1:0]  cfg_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hrq,
  input  logic           hlda,
  output logic [AW-1:0]  bus_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           irq
);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_XFER} st_t;

  st_t            st_q;
  logic [CSW-1:0] act_q;
  logic [AW-1:0]  addr_q [NCH];
  logic [AW-1:0]  cnt_q  [NCH];
  logic [NCH-1:0] dir_q, en_q, tc_q, flag_q;

  logic [NCH-1:0] elig;
  logic [CSW-1:0] pick;
  logic           busy, run, last, wr_ok, clr_rd;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = en_q[g] && dreq[g] && (cnt_q[g] != '0);
  end

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) pick = CSW'(i);
  end

  assign busy   = (st_q != S_IDLE);
  assign run    = (st_q == S_XFER) && hlda;
  assign last   = run && (cnt_q[act_q] == AW'(1));
  assign wr_ok  = cfg_wr && !(busy && (cfg_chan == act_q));
  assign clr_rd = cfg_rd && (cfg_reg == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      act_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (|elig) begin
          act_q <= pick;
          st_q  <= S_HOLD;
        end
        S_HOLD: if (hlda) st_q <= S_XFER;
        S_XFER: if (last) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
      dir_q  <= '0;
      en_q   <= '0;
      tc_q   <= '0;
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (run && (act_q == CSW'(i))) begin
          addr_q[i] <= addr_q[i] + AW'(1);
          cnt_q[i]  <= cnt_q[i] - AW'(1);
          if (last) begin
            en_q[i] <= 1'b0;
            tc_q[i] <= 1'b1;
          end
        end
        if (wr_ok && (cfg_chan == CSW'(i))) begin
          case (cfg_reg)
            2'd0: addr_q[i] <= cfg_wdata;
            2'd1: begin
              cnt_q[i] <= cfg_wdata;
              tc_q[i]  <= 1'b0;
            end
            2'd2: begin
              dir_q[i] <= cfg_wdata[0];
              en_q[i]  <= cfg_wdata[1];
            end
            default: ;
          endcase
        end
        if (clr_rd && (cfg_chan == CSW'(i))) flag_q[i] <= 1'b0;
        if (last && (act_q == CSW'(i)))      flag_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (cfg_reg)
      2'd0:    cfg_rdata = addr_q[cfg_chan];
      2'd1:    cfg_rdata = cnt_q[cfg_chan];
      2'd2:    cfg_rdata = AW'({en_q[cfg_chan], dir_q[cfg_chan]});
      default: cfg_rdata = AW'({flag_q[cfg_chan], tc_q[cfg_chan]});
    endcase
  end

  assign hrq      = busy;
  assign dack     = run ? (NCH'(1) << act_q) : '0;
  assign bus_addr = run ? addr_q[act_q] : '0;
  assign mem_rd   = run &&  dir_q[act_q];
  assign io_wr    = run &&  dir_q[act_q];
  assign io_rd    = run && !dir_q[act_q];
  assign mem_wr   = run && !dir_q[act_q];
  assign irq      = |flag_q;

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack,
  input logic           hrq,
  input logic           hlda,
  input logic [AW-1:0]  bus_addr,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic           irq
);
  logic strb;
  assign strb = mem_rd | mem_wr | io_rd | io_wr;

  // R3
  strobe_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb || (dack != '0)) |-> (hrq && hlda));

  // R4
  single_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack) && (strb == (dack != '0)));

  // R5
  strobe_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == io_wr) && (mem_wr == io_rd) && !(mem_rd && mem_wr));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && $past(strb) && (dack == $past(dack))) |-> (bus_addr == $past(bus_addr) + AW'(1)));

  // R7
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hrq) |-> ((dack == '0) && !strb));

  // R8
  release_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hrq) |-> irq);
endmodule

bind flyby_dma flyby_dma_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dack(dack), .hrq(hrq), .hlda(hlda),
  .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
);

// File: tb/flyby_dma_bench.sv
module flyby_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     cfg_chan = '0;
  logic [1:0]     cfg_reg = '0;
  logic           cfg_wr = 1'b0;
  logic           cfg_rd = 1'b0;
  logic [AW-1:0]  cfg_wdata = '0;
  logic [AW-1:0]  cfg_rdata;
  logic [NCH-1:0] dreq = '0;
  logic [NCH-1:0] dack;
  logic           hrq;
  logic           hlda = 1'b0;
  logic [AW-1:0]  bus_addr;
  logic           mem_rd, mem_wr, io_rd, io_wr, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flyby_dma #(.NCH(NCH), .AW(AW)) u_flyby_dma (
    .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_reg(cfg_reg),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dreq(dreq), .dack(dack), .hrq(hrq), .hlda(hlda), .bus_addr(bus_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input int ch, input int r, input int v);
    cfg_chan = 2'(ch); cfg_reg = 2'(r); cfg_wdata = AW'(v); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int r, input bit clr, output logic [AW-1:0] v);
    cfg_chan = 2'(ch); cfg_reg = 2'(r); cfg_rd = clr;
    #1 v = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  function automatic logic [8:0] quiet_vec();
    return {dack, mem_rd, mem_wr, io_rd, io_wr, irq};
  endfunction

  task automatic one_block(input int ch, input int dir, input int start, input int n,
                           input int lat, input bit pause);
    logic [AW-1:0] v;
    logic [7:0] exp_bus, got_bus;
    wr(ch, 0, start);
    wr(ch, 1, n);
    wr(ch, 2, 2 | dir);
    dreq[ch] = 1'b1;
    @(negedge clk);
    // R2 hold request raised, nothing driven yet
    chk(hrq === 1'b1, "R2 hrq after request", 32'(hrq), 1);
    for (int d = 0; d < lat; d++) begin
      chk({dack, mem_rd, mem_wr, io_rd, io_wr} === '0, "R3 quiet before hlda",
          32'({dack, mem_rd, mem_wr, io_rd, io_wr}), 0);
      @(negedge clk);
    end
    hlda = 1'b1;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (pause && k == 1) begin
        hlda = 1'b0;
        #1;
        // R3 pause while hlda low
        chk(hrq === 1'b1 && {dack, mem_rd, mem_wr, io_rd, io_wr} === '0, "R3 pause",
            32'({hrq, dack, mem_rd, mem_wr, io_rd, io_wr}), 32'h100);
        @(negedge clk);
        hlda = 1'b1;
        #1;
      end
      exp_bus = {4'(1 << ch), dir[0], !dir[0], !dir[0], dir[0]};
      got_bus = {dack, mem_rd, mem_wr, io_rd, io_wr};
      // R4 R5
      chk(got_bus === exp_bus, "R4/R5 word strobes", 32'(got_bus), 32'(exp_bus));
      chk(bus_addr === AW'(start + k), "R4 R6 word address", 32'(bus_addr), 32'(AW'(start + k)));
      chk(hrq === 1'b1, "R7 hrq held in block", 32'(hrq), 1);
      @(negedge clk);
    end
    // R7 release right after last word
    chk(hrq === 1'b0 && dack === '0, "R7 release", 32'({hrq, dack}), 0);
    chk(irq === 1'b1, "R8 irq on finish", 32'(irq), 1);
    hlda = 1'b0;
    dreq[ch] = 1'b0;
    rd(ch, 0, 0, v);
    chk(v === AW'(start + n), "R6 final address", 32'(v), 32'(AW'(start + n)));
    rd(ch, 1, 0, v);
    chk(v === '0, "R6 final count", 32'(v), 0);
    rd(ch, 2, 0, v);
    chk(v === AW'(dir), "R7 enable cleared", 32'(v), 32'(dir));
    rd(ch, 3, 1, v);
    chk(v === AW'(3), "R8 status tc and flag", 32'(v), 3);
    rd(ch, 3, 0, v);
    chk(v === AW'(1) && irq === 1'b0, "R8 flag cleared by read", 32'({irq, v}), 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    finish_up();
  end

  initial begin
    logic [AW-1:0] v;
    int order [4];
    int seen;
    logic [NCH-1:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk({hrq, dack, mem_rd, mem_wr, io_rd, io_wr, irq} === '0, "R11 outputs after reset",
        32'({hrq, dack, mem_rd, mem_wr, io_rd, io_wr, irq}), 0);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 4; r++) begin
        rd(c, r, 0, v);
        chk(v === '0, "R11 registers zero", 32'(v), 0);
      end

    // R1 independent readback
    for (int c = 0; c < NCH; c++) begin
      wr(c, 0, 16 * c + 3);
      wr(c, 1, 20 + c);
      wr(c, 2, c & 1);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(c, 0, 0, v); chk(v === AW'(16 * c + 3), "R1 address readback", 32'(v), 32'(16 * c + 3));
      rd(c, 1, 0, v); chk(v === AW'(20 + c), "R1 count readback", 32'(v), 32'(20 + c));
      rd(c, 2, 0, v); chk(v === AW'(c & 1), "R1 control readback", 32'(v), 32'(c & 1));
    end

    // R2 zero count never requests
    wr(1, 1, 0);
    wr(1, 2, 2);
    dreq[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk(hrq === 1'b0, "R2 zero count ignored", 32'(hrq), 0);
    dreq[1] = 1'b0;
    wr(1, 2, 0);

    // sweep channels, directions, counts
    for (int c = 0; c < NCH; c++)
      for (int d = 0; d < 2; d++)
        for (int n = 1; n < 16; n++)
          one_block(c, d, (c * 37 + n * 11 + d * 101) % 256, n, n % 3, (n % 3) == 0);
    one_block(2, 1, 250, 15, 1, 1);   // R6 wrap

    // R9 fixed priority, no preemption
    wr(0, 0, 8'h40); wr(0, 1, 2); wr(0, 2, 3);
    wr(1, 0, 8'h50); wr(1, 1, 3); wr(1, 2, 3);
    wr(2, 0, 8'h60); wr(2, 1, 2); wr(2, 2, 2);
    wr(3, 0, 8'h70); wr(3, 1, 2); wr(3, 2, 2);
    dreq = 4'b1110;
    seen = 0;
    prev = '0;
    for (int k = 0; k < 60; k++) begin
      hlda = hrq;
      #1;
      if (k == 4) dreq[0] = 1'b1;
      if (prev == '0 && dack != '0 && seen < 4) begin
        for (int b = 0; b < NCH; b++) if (dack[b]) order[seen] = b;
        seen++;
      end
      prev = dack;
      @(negedge clk);
    end
    hlda = 1'b0;
    dreq = '0;
    chk(seen == 4, "R9 blocks served", seen, 4);
    chk(order[0] == 1 && order[1] == 0 && order[2] == 2 && order[3] == 3, "R9 service order",
        (order[0] << 12) | (order[1] << 8) | (order[2] << 4) | order[3], 32'h1023);
    for (int c = 0; c < NCH; c++) rd(c, 3, 1, v);

    // R10 writes to active channel ignored, others accepted
    wr(0, 0, 8'h10); wr(0, 1, 5); wr(0, 2, 2);
    dreq[0] = 1'b1;
    hlda = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(0, 0, 8'hAA);
    wr(0, 1, 9);
    wr(2, 0, 8'h55);
    repeat (8) @(negedge clk);
    hlda = 1'b0;
    dreq = '0;
    rd(0, 0, 0, v); chk(v === 8'h15, "R10 active address write ignored", 32'(v), 32'h15);
    rd(0, 1, 0, v); chk(v === 8'h00, "R10 active count write ignored", 32'(v), 0);
    rd(2, 0, 0, v); chk(v === 8'h55, "R10 idle channel write taken", 32'(v), 32'h55);

    finish_up();
  end
endmodule